// File: doc/BRIEF.md
# Per-Vector Forced Coalesce Trigger

This block turns software "update now" requests into per-vector force-update requests for a host coalescing engine that serves up to seventeen interrupt vectors. Software writes a 32-bit mode register. Some of its bits are self-clearing triggers. Writing a 1 to a trigger bit arms a request for the matching vector. The coalescing engine sees the request, refreshes that vector's status block at once and raises its interrupt. It then accepts the request with a one-cycle acknowledge. The trigger bit clears itself on that acknowledge. Software only ever sets a trigger; it never clears one.

Bit 3 is the one legacy trigger. In INTx or MSI operation it forces the single status block. With MSI-X enabled, the same bit addresses vector 0. Vector n, for n from 1 to 16, uses bit 12+n. These higher triggers work only while MSI-X and multivector mode are both on. Every other bit of the register is ordinary read/write storage.

Each vector has its own two-state machine. In state SLOT_IDLE the vector has no request outstanding. In state SLOT_ARMED it drives its request. The transitions are:
- ARM goes from SLOT_IDLE to SLOT_ARMED on a write of 1 to the vector's bit while the vector is enabled.
- ACCEPT goes from SLOT_ARMED to SLOT_IDLE when the request is acknowledged.
- CANCEL goes from SLOT_ARMED to SLOT_IDLE when the vector loses its enable.

Vector 0 is always enabled. Every other transition holds the current state.

Top module: `force_coalesce_trig`

## Requirements
- R1: After reset, `force_req` is all zero and `rd_data` reads 0.
- R2: A write with `wr_data[3]`=1 raises `force_req[0]` in the cycle after the write, and `rd_data[3]` reads 1. This holds in every interrupt mode: MSI-X on or off, multivector on or off.
- R3: While `msix_en` and `multivec_en` are both 1, a write with `wr_data[12+n]`=1 (n = 1..16) raises `force_req[n]` in the next cycle, and `rd_data[12+n]` reads 1. Vectors are independent: writing one trigger leaves the others unchanged.
- R4: While `msix_en`&`multivec_en` is 0:
  - writes of 1 to bits 13..28 are discarded;
  - bits 13..28 read 0;
  - any armed request on vectors 1..16 is cancelled, so `force_req[16:1]` is 0 from the next cycle.
- R5: An armed request keeps its `force_req` bit at 1, and its trigger bit reads 1, until that vector's `force_ack` is sampled high.
- R6: When `force_req[n]` and `force_ack[n]` are both 1 at a clock edge, `force_req[n]` and its trigger bit are 0 from the next cycle.
- R7: Writing 0 to a trigger bit never clears it. Writing 1 to an already-armed trigger queues no second request, including a write made in the same cycle as the acknowledge.
- R8: All bits other than 3 and 13..28 store the written value on a write, read back unchanged, and are untouched by the trigger logic.
- R9: A request never starts without a write. With `wr_en` low, no `force_req` bit rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value (combinational) |
| msix_en | input | 1 | MSI-X interrupt mode enabled |
| multivec_en | input | 1 | Multivector mode enabled |
| force_ack | input | 17 | Per-vector accept from the coalescing engine |
| force_req | output | 17 | Per-vector force-update request |

## Verification
A vector machine left in the wrong state shows up directly at the ports. A machine stuck in SLOT_ARMED reads back as 1 and keeps its request high after the acknowledge, one cycle after the accepting edge. A missed ARM shows as a request that never rises in the cycle after the write. A broken mode gate shows as a high-vector request or readback appearing, or surviving, within one cycle while multivector MSI-X is off. The bench compares `rd_data` and `force_req` against a bench model every cycle, so any such divergence is reported within one clock.

// File: rtl/fct_pkg.sv
package fct_pkg;
    localparam int DATA_W_DEF = 32;
    localparam int NVEC_DEF   = 17;
    localparam int LEGACY_POS = 3;
    localparam int HI_BASE    = 12;

    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

    // register bit that triggers vector v
    function automatic int trig_pos(input int v);
        return (v == 0) ? LEGACY_POS : HI_BASE + v;
    endfunction
endpackage

// File: rtl/fct_slot.sv
module fct_slot
    import fct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_hit,
    input  logic ack,
    output logic req
);
    slot_state_e state_q, state_d;

    // transition logic: ARM, ACCEPT, CANCEL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (enable && set_hit) state_d = SLOT_ARMED;   // ARM
            end
            SLOT_ARMED: begin
                if (!enable)  state_d = SLOT_IDLE;             // CANCEL
                else if (ack) state_d = SLOT_IDLE;             // ACCEPT
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SLOT_IDLE:  req = 1'b0;
            SLOT_ARMED: req = 1'b1;
            default:    req = 1'b0;
        endcase
    end
endmodule

// File: rtl/fct_store.sv
module fct_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] plain_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     plain_q <= '0;
        else if (wr_en) plain_q <= wr_data & keep_mask;
    end
endmodule

// File: rtl/force_coalesce_trig.sv
module force_coalesce_trig
    import fct_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int NVEC   = NVEC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              msix_en,
    input  logic              multivec_en,
    input  logic [NVEC-1:0]   force_ack,
    output logic [NVEC-1:0]   force_req
);
    logic              multi_ok;
    logic [NVEC-1:0]   vec_en;
    logic [DATA_W-1:0] trig_mask;
    logic [DATA_W-1:0] trig_rd;
    logic [DATA_W-1:0] plain_q;

    assign multi_ok = msix_en & multivec_en;

    always_comb begin
        trig_mask = '0;
        for (int v = 0; v < NVEC; v++) trig_mask[trig_pos(v)] = 1'b1;
    end

    genvar gv;
    generate
        for (gv = 0; gv < NVEC; gv++) begin : g_vec
            if (gv == 0) begin : g_legacy
                assign vec_en[gv] = 1'b1;
            end else begin : g_multi
                assign vec_en[gv] = multi_ok;
            end
            fct_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .enable  (vec_en[gv]),
                .set_hit (wr_en & wr_data[trig_pos(gv)]),
                .ack     (force_ack[gv]),
                .req     (force_req[gv])
            );
        end
    endgenerate

    fct_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .keep_mask (~trig_mask),
        .plain_q   (plain_q)
    );

    always_comb begin
        trig_rd = '0;
        for (int v = 0; v < NVEC; v++)
            trig_rd[trig_pos(v)] = force_req[v] & vec_en[v];
    end

    assign rd_data = plain_q | trig_rd;
endmodule

// File: rtl/fct_checker.sv
module fct_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        msix_en,
    input logic        multivec_en,
    input logic [16:0] force_ack,
    input logic [16:0] force_req
);
    localparam logic [31:0] PLAIN = ~(32'h1FFF_E000 | 32'h0000_0008);
    logic mode_ok;
    assign mode_ok = msix_en & multivec_en;

    AST_LEGACY_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[3] && !force_req[0] |=> force_req[0]); // R2
    AST_HI_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok && wr_en && wr_data[13] && !force_req[1] |=> force_req[1]); // R3
    AST_GATED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |-> rd_data[28:13] == 16'h0); // R4
    AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> force_req[16:1] == 16'h0); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        force_req[0] && !force_ack[0] |=> force_req[0]); // R5
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req & force_ack) != 17'h0 |=> (force_req & $past(force_req & force_ack)) == 17'h0); // R6
    AST_NO_REQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        force_req[0] && force_ack[0] && wr_en && wr_data[3] |=> !force_req[0]); // R7
    AST_PLAIN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data & PLAIN) == ($past(wr_data) & PLAIN)); // R8
    AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data & PLAIN)); // R8
    AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (force_req & ~$past(force_req)) == 17'h0); // R9
endmodule

bind force_coalesce_trig fct_checker u_fct_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .msix_en     (msix_en),
    .multivec_en (multivec_en),
    .force_ack   (force_ack),
    .force_req   (force_req)
);

// File: tb/force_coalesce_trig_bench.sv
module force_coalesce_trig_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TRIG = 32'h1FFF_E008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        msix_en = 1'b0;
    logic        multivec_en = 1'b0;
    logic [16:0] force_ack = '0;
    logic [16:0] force_req;

    int checks = 0;
    int failures = 0;
    logic [16:0] m_pend = '0;
    logic [31:0] m_plain = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    force_coalesce_trig u_force_coalesce_trig (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .msix_en(msix_en), .multivec_en(multivec_en),
        .force_ack(force_ack), .force_req(force_req)
    );

    function automatic int bitpos(input int v);
        return (v == 0) ? 3 : 12 + v;
    endfunction

    function automatic logic [16:0] next_pend(input logic [16:0] p, input logic we,
        input logic [31:0] wd, input logic [16:0] ak, input logic mode);
        logic [16:0] n;
        for (int v = 0; v < 17; v++) begin
            if (v != 0 && !mode) n[v] = 1'b0;
            else if (p[v])       n[v] = ~ak[v];
            else                 n[v] = we & wd[bitpos(v)];
        end
        return n;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [16:0] p, input logic [31:0] pl,
        input logic mode);
        logic [31:0] r;
        r = pl;
        for (int v = 0; v < 17; v++)
            if (v == 0 || mode) r[bitpos(v)] = p[v];
        return r;
    endfunction

    task automatic step(input logic we, input logic [31:0] wd, input logic [16:0] ak,
        input logic mx, input logic mv);
        logic [16:0] np;
        logic [31:0] npl;
        wr_en = we; wr_data = wd; force_ack = ak; msix_en = mx; multivec_en = mv;
        np  = next_pend(m_pend, we, wd, ak, mx & mv);
        npl = we ? (wd & ~TRIG) : m_plain;
        @(posedge clk);
        @(negedge clk);
        m_pend = np; m_plain = npl;
        wr_en = 1'b0; force_ack = '0;
    endtask

    task automatic check_all(input string req);
        checks++;
        if (force_req !== m_pend || rd_data !== exp_rd(m_pend, m_plain, msix_en & multivec_en)) begin
            failures++;
            $display("FAIL %s req=%h exp_req=%h rd=%h exp_rd=%h", req, force_req, m_pend,
                     rd_data, exp_rd(m_pend, m_plain, msix_en & multivec_en));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // legacy trigger in INTx/MSI mode
        step(1'b1, 32'h0000_0008, '0, 1'b0, 1'b0);
        check_all("R2 legacy arm");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0, '0, 1'b0, 1'b0);
            check_all("R5 held without ack");
        end
        step(1'b0, '0, 17'h1, 1'b0, 1'b0);
        check_all("R6 cleared after ack");

        // high triggers discarded unless multivector MSI-X
        step(1'b1, 32'h1FFF_E000, '0, 1'b0, 1'b1);
        check_all("R4 discarded msix off");
        step(1'b1, 32'h1FFF_E000, '0, 1'b1, 1'b0);
        check_all("R4 discarded mv off");

        // high vector arm in multivector MSI-X
        step(1'b1, 32'h1 << (12 + 5), '0, 1'b1, 1'b1);
        check_all("R3 vector5 arm");
        step(1'b1, 32'h1 << (12 + 16), '0, 1'b1, 1'b1);
        check_all("R3 vector16 arm, vector5 kept");
        step(1'b1, 32'h0, '0, 1'b1, 1'b1);
        check_all("R7 write zero keeps triggers");
        step(1'b1, 32'h1 << 17, 17'h1 << 5, 1'b1, 1'b1);
        check_all("R7 write during ack no requeue");

        // plain storage
        step(1'b1, 32'hA5A5_A5A5 & ~TRIG, '0, 1'b1, 1'b1);
        check_all("R8 plain write");
        step(1'b0, 32'hFFFF_FFFF, '0, 1'b1, 1'b1);
        check_all("R8 plain held");

        // cancel on mode drop
        step(1'b1, 32'h0000_4000, '0, 1'b1, 1'b1);
        check_all("R3 vector2 arm");
        step(1'b0, '0, '0, 1'b1, 1'b0);
        check_all("R4 cancel on mode drop");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic we, mx, mv;
            logic [31:0] wd;
            logic [16:0] ak;
            we = ($urandom % 4) == 0;
            wd = $urandom;
            ak = $urandom & $urandom;
            mx = ($urandom % 8) != 0;
            mv = ($urandom % 8) != 0;
            step(we, wd, ak, mx, mv);
            check_all("R9 random sequence");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule